// File: doc/BRIEF.md
# Two-Wire Register Slave with Wake-Up Refusal

This block is the target side of a two-wire serial bus (I2C-style, standard and fast mode, up to 400 kHz). It never starts a transfer. It samples the clock and data lines through a synchroniser, recognises start and stop conditions, compares the 7-bit address in the first byte with its own fixed address, and then moves bytes between the bus and an external register file through a write strobe port and a combinational read port.

A write transaction carries one pointer byte, then zero or more data bytes. Each data byte lands at the pointer, and the pointer then moves up by one. A read transaction returns bytes from the pointer, most significant bit first, and moves the pointer up after each byte. It ends when the master does not acknowledge a byte. The pointer is kept between transactions, so the usual register read is a pointer write, a repeated start and a read.

The power controller holds `sleep_i` high while the chip is halted. A start condition seen in that state arms a one-shot refusal: the next address byte is not acknowledged, whatever its value, and the master must repeat the transfer. Each start condition also gives a one-cycle `bus_activity_o` pulse, which the power controller uses to leave the halt state.

Top module: `tws_slave`

## Requirements
- R1: An address byte of 0xA2 (address 0x51, direction bit 0 = write) or 0xA3 (direction bit 1 = read) is acknowledged: the slave holds SDA low through the ninth clock.
- R2: An address byte with any other 7-bit address is not acknowledged. No register write follows, and the slave leaves SDA released until the next start condition.
- R3: In a write, the first byte after the address loads the pointer from its low PTR_W bits. Each later byte gives one single-cycle `wr_en_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. The pointer then increments. Every byte of the write is acknowledged.
- R4: In a read, each byte is taken from `rd_data_i` at `rd_addr_o` (the pointer) and sent most significant bit first. The pointer increments after each byte, and the read goes on while the master acknowledges.
- R5: A master NACK ends a read. The slave releases SDA and ignores further clocks until the next start condition.
- R6: A start condition while `sleep_i` is high arms the refusal. The next address byte is not acknowledged even when it matches, and the refusal is cleared by that byte. Later matching address bytes are acknowledged.
- R7: `bus_activity_o` pulses high for exactly one cycle for each start condition, repeated starts included.
- R8: The pointer wraps modulo 2^PTR_W, for writes and for reads.
- R9: A stop condition at any point returns the slave to idle. A partly received byte is discarded, causes no write, and leaves the pointer unchanged.
- R10: A repeated start begins a new address phase, and the pointer keeps its value across transactions.
- R11: SDA is only pulled low, through `sda_oe_o`. That enable changes only while the synchronised SCL is low, and it is 0 during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| sleep_i | input | 1 | High while the chip is in the halt state |
| bus_activity_o | output | 1 | One-cycle pulse per start condition |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | PTR_W | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | PTR_W | Register read address (current pointer) |
| rd_data_i | input | 8 | Register read data for `rd_addr_o` |

## Verification
The bench checks that the wake-up refusal fires once and only once. A design that ignored it would acknowledge straight after wake-up. A design that never cleared it would refuse the retry. A design that cleared it only on a matching address would refuse the good address that follows a stray one. The bench also aborts a byte half-way with a stop and then reads back at the old pointer: a design that kept the partial bits would write a register or move the pointer. The remaining cases are clocks sent after a master NACK, which must return all ones because SDA is released, and writes and reads across the top of the pointer range, where a missing wrap would show up as the wrong address.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_AACK = 3'd2,
        ST_WR   = 3'd3,
        ST_WACK = 3'd4,
        ST_RD   = 3'd5,
        ST_RACK = 3'd6
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tws_cond.sv
module tws_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise_o = scl_s & ~prev_q.scl;
    assign scl_fall_o = ~scl_s & prev_q.scl;
    assign start_o    = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_o     = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h51,
    parameter int         PTR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sleep_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              bus_activity_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        tws_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              rd;
        logic              first;
        logic              mack;
        logic              wake;
        logic              act;
        logic              wr;
        logic [PTR_W-1:0]  wa;
        logic [BYTE_W-1:0] wd;
    } eng_t;

    eng_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.wr  = 1'b0;
        r_d.act = 1'b0;
        if (stop_i) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_i) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
            r_d.act = 1'b1;
            if (sleep_i) begin
                r_d.wake = 1'b1;
            end
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.oe = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.wake = 1'b0;
                        if (r_q.sh[BYTE_W-1:1] == DEV_ADDR && !r_q.wake) begin
                            r_d.oe = 1'b1;
                            r_d.rd = r_q.sh[0];
                            r_d.st = ST_AACK;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        r_d.cnt   = '0;
                        r_d.first = 1'b1;
                        if (r_q.rd) begin
                            r_d.sh = rd_data_i;
                            r_d.oe = ~rd_data_i[BYTE_W-1];
                            r_d.st = ST_RD;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.oe    = 1'b1;
                        r_d.st    = ST_WACK;
                        r_d.first = 1'b0;
                        if (r_q.first) begin
                            r_d.ptr = r_q.sh[PTR_W-1:0];
                        end else begin
                            r_d.wr  = 1'b1;
                            r_d.wa  = r_q.ptr;
                            r_d.wd  = r_q.sh;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_OUT) begin
                            r_d.oe   = 1'b0;
                            r_d.st   = ST_RACK;
                            r_d.ptr  = r_q.ptr + 1'b1;
                            r_d.mack = 1'b0;
                        end else begin
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe  = ~r_q.sh[BYTE_W-2];
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.sh  = rd_data_i;
                            r_d.oe  = ~rd_data_i[BYTE_W-1];
                            r_d.cnt = '0;
                            r_d.st  = ST_RD;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o       = r_q.oe;
    assign bus_activity_o = r_q.act;
    assign wr_en_o        = r_q.wr;
    assign wr_addr_o      = r_q.wa;
    assign wr_data_o      = r_q.wd;
    assign rd_addr_o      = r_q.ptr;

    // R11: the pull-down only moves while the clock line is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> !scl_lvl);

    // R3: each write strobe lasts a single cycle
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |=> !r_q.wr);

    // R10: a start condition always reopens the address phase
    assert_restart_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (r_q.st == ST_ADDR && r_q.cnt == '0));

    // R6: an armed refusal leaves the bus released after the address byte
    assert_wake_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR && r_q.wake && scl_fall && r_q.cnt == LAST_BIT
         && !start_i && !stop_i) |=> (!r_q.oe && r_q.st == ST_IDLE && !r_q.wake));

    // R9: a stop condition always lands in idle with SDA released
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (r_q.st == ST_IDLE && !r_q.oe));

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h51,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              sleep_i,
    output logic              bus_activity_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    logic [1:0] lines_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    tws_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    tws_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[1]),
        .sda_s      (lines_s[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    tws_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_lvl        (lines_s[1]),
        .sda_lvl        (lines_s[0]),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .start_i        (start_c),
        .stop_i         (stop_c),
        .sleep_i        (sleep_i),
        .rd_data_i      (rd_data_i),
        .sda_oe_o       (sda_oe_o),
        .bus_activity_o (bus_activity_o),
        .wr_en_o        (wr_en_o),
        .wr_addr_o      (wr_addr_o),
        .wr_data_o      (wr_data_o),
        .rd_addr_o      (rd_addr_o)
    );

endmodule

// File: tb/tws_slave_test.sv
`timescale 1ns/1ps
module tws_slave_test;

    localparam int PW = 4;
    localparam int Q  = 30;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sleep = 1'b0;
    logic sda_oe, bus_act, wr_en;
    logic [PW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [7:0] mem [1<<PW];

    wire sda_line = sda_m & ~sda_oe;

    tws_slave #(.DEV_ADDR(7'h51), .PTR_W(PW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .sleep_i(sleep), .bus_activity_o(bus_act),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    int errors = 0, checks = 0, starts = 0, acts = 0;
    logic [PW+7:0] exp_q [$];

    function automatic logic [7:0] init_val(input int i);
        return (8'(i) * 8'h11) ^ 8'h3C;
    endfunction

    initial for (int i = 0; i < (1<<PW); i++) mem[i] = init_val(i);
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;
    assign rd_data = mem[rd_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for register writes (R3, R8)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected write", int'({wr_addr, wr_data}), 0);
            end else begin
                logic [PW+7:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R3/R8 write", int'({wr_addr, wr_data}), int'(e));
            end
        end
        if (rst_n && bus_act) acts++;
    end

    task automatic expect_wr(input logic [PW-1:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic qtr;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bstart;
        sda_m = 1'b1; qtr; scl_m = 1'b1; qtr; sda_m = 1'b0; qtr; scl_m = 1'b0; qtr;
        starts++;
    endtask

    task automatic bstop;
        sda_m = 1'b0; qtr; scl_m = 1'b1; qtr; sda_m = 1'b1; qtr; qtr;
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; qtr; scl_m = 1'b1; qtr; s = sda_line; qtr; scl_m = 1'b0; qtr;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~mack, s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        repeat (10) @(posedge clk);
        #1;
        chk(sda_oe == 1'b0 && wr_en == 1'b0 && bus_act == 1'b0, "R11 reset state",
            int'({sda_oe, wr_en, bus_act}), 0);
        rst_n = 1'b1;
        qtr;

        // R1 R3: pointer write then two data bytes
        bstart;
        wbyte(8'hA2, ack); chk(ack, "R1 write address ack", ack, 1);
        wbyte(8'h03, ack); chk(ack, "R3 pointer byte ack", ack, 1);
        expect_wr(4'd3, 8'hA5); expect_wr(4'd4, 8'h5A);
        wbyte(8'hA5, ack); chk(ack, "R3 data ack", ack, 1);
        wbyte(8'h5A, ack); chk(ack, "R3 data ack", ack, 1);
        bstop;
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        chk(acts == starts, "R7 activity pulses", acts, starts);

        // R4 R5 R10: pointer set, repeated start, read three bytes
        bstart;
        wbyte(8'hA2, ack);
        wbyte(8'h03, ack);
        bstart;
        wbyte(8'hA3, ack); chk(ack, "R10 read address after repeated start", ack, 1);
        rbyte(1'b1, b); chk(b == 8'hA5, "R4 read byte 0", b, 8'hA5);
        rbyte(1'b1, b); chk(b == 8'h5A, "R4 read byte 1", b, 8'h5A);
        rbyte(1'b0, b); chk(b == init_val(5), "R4 read byte 2", b, init_val(5));
        rbyte(1'b0, b); chk(b == 8'hFF, "R5 released after master nack", b, 8'hFF);
        chk(sda_oe == 1'b0, "R5 oe low after nack", sda_oe, 0);
        bstop;

        // R10: pointer kept across transactions (now 6)
        bstart;
        wbyte(8'hA3, ack); chk(ack, "R1 read address ack", ack, 1);
        rbyte(1'b0, b); chk(b == init_val(6), "R10 pointer preserved", b, init_val(6));
        bstop;

        // R2: foreign address
        bstart;
        wbyte(8'hA0, ack); chk(!ack, "R2 foreign address nack", ack, 0);
        wbyte(8'h01, ack); chk(!ack, "R2 stays released", ack, 0);
        wbyte(8'hEE, ack); chk(!ack, "R2 stays released", ack, 0);
        bstop;
        chk(exp_q.size() == 0, "R2 no write", exp_q.size(), 0);

        // R8: wrap on write and read
        bstart;
        wbyte(8'hA2, ack); wbyte(8'h0F, ack);
        expect_wr(4'd15, 8'h11); expect_wr(4'd0, 8'h22);
        wbyte(8'h11, ack); wbyte(8'h22, ack);
        bstop;
        bstart;
        wbyte(8'hA2, ack); wbyte(8'h0F, ack);
        bstart;
        wbyte(8'hA3, ack);
        rbyte(1'b1, b); chk(b == 8'h11, "R8 read at top", b, 8'h11);
        rbyte(1'b0, b); chk(b == 8'h22, "R8 read wrapped", b, 8'h22);
        bstop;

        // R9: stop in the middle of a data byte
        bstart;
        wbyte(8'hA2, ack); wbyte(8'h02, ack);
        for (int i = 0; i < 4; i++) begin
            logic s;
            bit_io(1'b1, s);
        end
        bstop;
        bstart;
        wbyte(8'hA3, ack);
        rbyte(1'b0, b); chk(b == init_val(2), "R9 partial byte discarded", b, init_val(2));
        bstop;

        // R6: wake-up refusal then retry
        sleep = 1'b1;
        bstart;
        sleep = 1'b0;
        wbyte(8'hA2, ack); chk(!ack, "R6 first address after wake refused", ack, 0);
        bstop;
        bstart;
        wbyte(8'hA2, ack); chk(ack, "R6 retry acknowledged", ack, 1);
        bstop;

        // R6: refusal consumed by a foreign address
        sleep = 1'b1;
        bstart;
        sleep = 1'b0;
        wbyte(8'h40, ack); chk(!ack, "R6 foreign after wake", ack, 0);
        bstart;
        wbyte(8'hA2, ack); chk(ack, "R6 refusal cleared by any address", ack, 1);
        bstop;

        qtr;
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        chk(acts == starts, "R7 one pulse per start", acts, starts);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule